// File: doc/BRIEF.md
# Interrupt Message Moderation Controller

This block decides when each of a small set of interrupt vectors should raise a message request. Queue producers pulse an event line per vector. The block counts those events and raises a one-cycle request when one of these happens: enough events have built up, a coalescing period ends with work waiting, or a low-latency credit lets a single event through at once. When a request goes unacknowledged, the block raises it again after a programmable number of coalescing periods.

Software programs each vector through a single-cycle register port. Each vector has one 32-bit attribute word that holds all of its moderation settings. It also has a write-only word that restarts the resend wait. A shared prescaler turns the clock into a microsecond tick and then into the 8-microsecond unit used by both timers.

Top module: `irq_moderator`

## Requirements
- R1: Vector i's attribute word is at byte address 0x2000 + 8*i and reads back as written. Its fields are: bits 7:0 the pending limit, bits 15:8 the coalescing period, bits 23:16 the credit refill period, bits 28:24 the credit cap, and bits 31:29 the resend count.
- R2: A write to an index at or above NUM_VEC changes no attribute word, and a read of such an index returns zero. A read of any counter-clear word at 0x2004 + 8*i returns zero.
- R3: After reset every attribute word reads zero and no request is raised.
- R4: With a nonzero pending limit L, the event that brings the pending count to 8*L raises the request on the next cycle and empties the count. L = 0 never fires on count.
- R5: When a coalescing period of C units ends with at least one event pending, a request is raised. Each unit is 8 microseconds. The period restarts on each request and on each attribute write. No request is raised while nothing is pending.
- R6: With a coalescing period of 0, any pending event raises a request on the next cycle.
- R7: Each credit refill period adds one credit, up to 8 times the credit cap. While a credit is held, an event consumes it and raises a request on the next cycle. A cap or refill period of 0 disables credits.
- R8: While a request is unacknowledged and the resend count N is nonzero, a new request is raised at the end of the N-th coalescing period after it. An acknowledge pulse ends this wait. N = 0 never resends.
- R9: Writing a 1 to bit 29 of vector i's counter-clear word at 0x2004 + 8*i restarts that vector's resend wait from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| evt_pulse | input | NUM_VEC | One event per high cycle, per vector |
| msg_ack | input | NUM_VEC | Acknowledge of the outstanding request, per vector |
| msg_req | output | NUM_VEC | One-cycle message request, per vector |

## Verification
The count threshold is driven with bursts just below, at, and at multiples of 8*L. A limit of 0 is also tried. These runs separate an off-by-one compare, a count left uncleared after firing, and a limit that is not scaled by 8. After each burst, setting a coalescing period of 0 empties the leftover count, which shows whether exactly the expected remainder was kept. The period is tried with one event pending and with none. Credits are tried after a long refill, which shows the cap at 8 credits. The resend wait is tried acknowledged, unacknowledged, and restarted by the clear word, which shows whether the wait counts periods from the right starting point.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;

    // Per-vector moderation settings; field positions are software-visible.
    typedef struct packed {
        logic [2:0] resend;     // 31:29 periods to wait before re-raising
        logic [4:0] ll_credit;  // 28:24 credit cap, units of 8
        logic [7:0] ll_period;  // 23:16 credit refill period, 8 us units
        logic [7:0] coal;       // 15:8  coalescing period, 8 us units
        logic [7:0] pend_lim;   // 7:0   pending threshold, units of 8
    } vec_attr_t;

    localparam int UNIT_SHIFT = 3;  // count and time fields scale by 8
    localparam int CLR_BIT    = 29; // resend-restart bit in the clear word

endpackage

// File: rtl/irqmod_tick.sv
module irqmod_tick #(
    parameter int TICK_DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_unit
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [2:0]       sub;
        logic             unit;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.unit = 1'b0;
        if (st_q.div == DIV_W'(TICK_DIV - 1)) begin
            st_d.div = '0;
            st_d.sub = st_q.sub + 3'd1;
            if (st_q.sub == 3'd7) begin
                st_d.unit = 1'b1;
            end
        end else begin
            st_d.div = st_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_unit = st_q.unit;

    AST_UNIT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_unit |=> !tick_unit); // R5

endmodule

// File: rtl/irqmod_regs.sv
module irqmod_regs
    import irqmod_pkg::*;
#(
    parameter int               NUM_VEC   = 4,
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output vec_attr_t [NUM_VEC-1:0] attr_o,
    output logic [NUM_VEC-1:0]      attr_wr_o,
    output logic [NUM_VEC-1:0]      clr_resend_o
);
    localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    vec_attr_t [NUM_VEC-1:0] attr_d, attr_q;

    logic [ADDR_W-1:0] off;
    logic              hit;
    logic              is_clr;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        off    = addr - BASE_ADDR;
        idx    = off[3 +: IDX_W];
        is_clr = off[2];
        hit    = (addr >= BASE_ADDR) && (off[1:0] == 2'b00) &&
                 ({3'b000, off[ADDR_W-1:3]} < ADDR_W'(NUM_VEC));
    end

    always_comb begin
        attr_d       = attr_q;
        attr_wr_o    = '0;
        clr_resend_o = '0;
        rdata        = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (hit && idx == IDX_W'(i)) begin
                if (wr_en && !is_clr) begin
                    attr_d[i]    = vec_attr_t'(wdata);
                    attr_wr_o[i] = 1'b1;
                end
                if (wr_en && is_clr && wdata[CLR_BIT]) begin
                    clr_resend_o[i] = 1'b1;
                end
                if (rd_en && !is_clr) begin
                    rdata = attr_q[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q <= '0;
        end else begin
            attr_q <= attr_d;
        end
    end

    assign attr_o = attr_q;

    AST_ATTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && !is_clr) |=> (attr_q[$past(idx)] == $past(wdata))); // R1

    AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(attr_q)); // R2

endmodule

// File: rtl/irqmod_vec.sv
module irqmod_vec
    import irqmod_pkg::*;
#(
    parameter int PEND_W = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_unit,
    input  vec_attr_t attr,
    input  logic      attr_wr,
    input  logic      clr_resend,
    input  logic      evt,
    input  logic      ack,
    output logic      req
);
    localparam int LIM_W = 8 + UNIT_SHIFT;
    localparam int CAP_W = 5 + UNIT_SHIFT;

    typedef struct packed {
        logic [PEND_W-1:0] pend;
        logic [7:0]        coal_cnt;
        logic [7:0]        ll_cnt;
        logic [CAP_W-1:0]  credit;
        logic [2:0]        resend_cnt;
        logic              outst;
        logic              req;
    } vec_st_t;

    vec_st_t st_d, st_q;

    logic [LIM_W-1:0]  lim8;
    logic [CAP_W-1:0]  cap;
    logic [7:0]        coal_len;
    logic              period_end;
    logic              ll_en;
    logic              ll_end;
    logic [CAP_W-1:0]  cred;
    logic              ll_fire;
    logic [PEND_W-1:0] cnt_inc;
    logic              thresh_fire;
    logic              coal_fire;
    logic              resend_step;
    logic              resend_fire;
    logic              fire;

    always_comb begin
        lim8     = {attr.pend_lim, {UNIT_SHIFT{1'b0}}};
        cap      = {attr.ll_credit, {UNIT_SHIFT{1'b0}}};
        coal_len = (attr.coal == 8'd0) ? 8'd1 : attr.coal;

        period_end = tick_unit &&
                     ({1'b0, st_q.coal_cnt} + 9'd1 >= {1'b0, coal_len});

        ll_en  = (attr.ll_credit != 5'd0) && (attr.ll_period != 8'd0);
        ll_end = tick_unit && ll_en &&
                 ({1'b0, st_q.ll_cnt} + 9'd1 >= {1'b0, attr.ll_period});

        // Credits: clamp to the cap, spend one on an event, refill one per period.
        cred    = (st_q.credit > cap) ? cap : st_q.credit;
        ll_fire = evt && ll_en && (cred != '0);
        if (ll_fire) begin
            cred = cred - CAP_W'(1);
        end
        if (ll_end && cred < cap) begin
            cred = cred + CAP_W'(1);
        end

        // Saturating pending count including this cycle's event.
        cnt_inc = st_q.pend;
        if (evt && st_q.pend != '1) begin
            cnt_inc = st_q.pend + PEND_W'(1);
        end

        thresh_fire = (attr.pend_lim != 8'd0) && (cnt_inc >= PEND_W'(lim8));
        coal_fire   = (cnt_inc != '0) && ((attr.coal == 8'd0) || period_end);

        resend_step = st_q.outst && (attr.resend != 3'd0) && period_end;
        resend_fire = resend_step &&
                      ({1'b0, st_q.resend_cnt} + 4'd1 >= {1'b0, attr.resend});

        fire = thresh_fire || coal_fire || ll_fire || resend_fire;
    end

    always_comb begin
        st_d        = st_q;
        st_d.req    = fire;
        st_d.credit = cred;
        st_d.pend   = fire ? '0 : cnt_inc;

        if (fire || period_end || attr_wr) begin
            st_d.coal_cnt = '0;
        end else if (tick_unit) begin
            st_d.coal_cnt = st_q.coal_cnt + 8'd1;
        end

        if (!ll_en || ll_end || attr_wr) begin
            st_d.ll_cnt = '0;
        end else if (tick_unit) begin
            st_d.ll_cnt = st_q.ll_cnt + 8'd1;
        end

        if (fire) begin
            st_d.outst      = 1'b1;
            st_d.resend_cnt = '0;
        end else if (ack) begin
            st_d.outst      = 1'b0;
            st_d.resend_cnt = '0;
        end else if (resend_step) begin
            st_d.resend_cnt = st_q.resend_cnt + 3'd1;
        end

        if (clr_resend) begin
            st_d.resend_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req = st_q.req;

    AST_PEND_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ((attr.pend_lim != 8'd0) && $stable(attr.pend_lim)) |->
        (st_q.pend < PEND_W'(lim8))); // R4

    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(attr.ll_credit) |-> (st_q.credit <= cap)); // R7

    AST_IDLE_NO_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.outst |-> (st_q.resend_cnt == 3'd0)); // R8

    AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_resend |=> (st_q.resend_cnt == 3'd0)); // R9

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
    import irqmod_pkg::*;
#(
    parameter int                NUM_VEC   = 4,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h2000,
    parameter int                TICK_DIV  = 200,
    parameter int                PEND_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_VEC-1:0] evt_pulse,
    input  logic [NUM_VEC-1:0] msg_ack,
    output logic [NUM_VEC-1:0] msg_req
);
    logic                    tick_unit;
    vec_attr_t [NUM_VEC-1:0] attr;
    logic [NUM_VEC-1:0]      attr_wr;
    logic [NUM_VEC-1:0]      clr_resend;

    irqmod_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_unit (tick_unit)
    );

    irqmod_regs #(
        .NUM_VEC   (NUM_VEC),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (reg_wr),
        .rd_en        (reg_rd),
        .addr         (reg_addr),
        .wdata        (reg_wdata),
        .rdata        (reg_rdata),
        .attr_o       (attr),
        .attr_wr_o    (attr_wr),
        .clr_resend_o (clr_resend)
    );

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        irqmod_vec #(.PEND_W(PEND_W)) u_vec (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_unit  (tick_unit),
            .attr       (attr[v]),
            .attr_wr    (attr_wr[v]),
            .clr_resend (clr_resend[v]),
            .evt        (evt_pulse[v]),
            .ack        (msg_ack[v]),
            .req        (msg_req[v])
        );
    end

endmodule

// File: tb/irq_moderator_test.sv
`timescale 1ns/100ps
module irq_moderator_test;
    localparam int NV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NV-1:0] evt_pulse = '0;
    logic [NV-1:0] msg_ack = '0;
    logic [NV-1:0] msg_req;

    int tests = 0;
    int fails = 0;
    int fires [NV];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_moderator #(.NUM_VEC(NV), .TICK_DIV(2)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .msg_ack(msg_ack), .msg_req(msg_req)
    );

    initial for (int v = 0; v < NV; v++) fires[v] = 0;

    always @(posedge clk) begin
        #1;
        for (int v = 0; v < NV; v++) if (msg_req[v]) fires[v]++;
    end

    // {pend_lim[7:0], events[7:0], expected fires[3:0]}
    localparam logic [19:0] ROWS [7] = '{
        {8'd1, 8'd8,  4'd1}, {8'd1, 8'd7,  4'd0}, {8'd1, 8'd16, 4'd2},
        {8'd2, 8'd15, 4'd0}, {8'd2, 8'd16, 4'd1}, {8'd0, 8'd20, 4'd0},
        {8'd1, 8'd20, 4'd2}
    };

    function automatic logic [15:0] a_attr(int v); return 16'h2000 + 16'(v * 8); endfunction
    function automatic logic [15:0] a_clr(int v);  return 16'h2004 + 16'(v * 8); endfunction
    function automatic logic [31:0] mk(int rs, int cr, int llp, int co, int lim);
        return {3'(rs), 5'(cr), 8'(llp), 8'(co), 8'(lim)};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata; reg_rd = 1'b0;
    endtask

    task automatic send(int v, int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); evt_pulse[v] = 1'b1;
        end
        @(negedge clk); evt_pulse[v] = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_fire(int v, int maxc, output bit got);
        int base = fires[v];
        got = 1'b0;
        for (int k = 0; k < maxc && !got; k++) begin
            @(negedge clk);
            if (fires[v] > base) got = 1'b1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int base;
        bit got;

        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R3: reset state
        rd(a_attr(0), d);
        check(d == 0, "R3 attr after reset", int'(d), 0);
        check(msg_req == '0, "R3 no request after reset", int'(msg_req), 0);

        // R1: readback and field layout
        wr(a_attr(0), 32'hA5C3_7E19);
        rd(a_attr(0), d);
        check(d == 32'hA5C3_7E19, "R1 attr readback", int'(d), int'(32'hA5C3_7E19));

        // R2: out of range ignored, clear word reads zero
        wr(a_attr(NV), 32'h1234_5678);
        rd(a_attr(NV), d);
        check(d == 0, "R2 out-of-range read", int'(d), 0);
        rd(a_attr(0), d);
        check(d == 32'hA5C3_7E19, "R2 vector 0 untouched", int'(d), int'(32'hA5C3_7E19));
        rd(a_clr(1), d);
        check(d == 0, "R2 clear word read", int'(d), 0);

        // R4 threshold table, then R6 drain with coalescing period 0
        for (int r = 0; r < 7; r++) begin
            int lim = int'(ROWS[r][19:12]);
            int nev = int'(ROWS[r][11:4]);
            int exp = int'(ROWS[r][3:0]);
            int res = (lim != 0) ? nev % (8 * lim) : nev;
            wr(a_attr(0), mk(0, 0, 0, 255, lim));
            base = fires[0];
            send(0, nev);
            idle(3);
            check(fires[0] - base == exp, "R4 threshold fires", fires[0] - base, exp);
            base = fires[0];
            wr(a_attr(0), mk(0, 0, 0, 0, lim));
            idle(3);
            check(fires[0] - base == ((res > 0) ? 1 : 0), "R6 immediate drain",
                  fires[0] - base, (res > 0) ? 1 : 0);
        end

        // R5: coalescing period with one pending event, then none pending
        wr(a_attr(3), mk(0, 0, 0, 4, 0));
        base = fires[3];
        send(3, 1);
        idle(40);
        check(fires[3] == base, "R5 no early fire", fires[3] - base, 0);
        idle(40);
        check(fires[3] - base == 1, "R5 fire at period end", fires[3] - base, 1);
        base = fires[3];
        idle(150);
        check(fires[3] == base, "R5 empty periods silent", fires[3] - base, 0);

        // R7: credits capped at 8 after a long refill, disabled with cap 0
        wr(a_attr(2), mk(0, 1, 1, 255, 0));
        idle(200);
        base = fires[2];
        send(2, 10);
        idle(3);
        check((fires[2] - base >= 8) && (fires[2] - base <= 9), "R7 credit-limited fires",
              fires[2] - base, 8);
        wr(a_attr(2), mk(0, 0, 1, 255, 0));
        base = fires[2];
        send(2, 1);
        idle(5);
        check(fires[2] == base, "R7 credits disabled", fires[2] - base, 0);
        wr(a_attr(2), mk(0, 0, 1, 0, 0));
        idle(3);
        check(fires[2] - base == 1, "R6 drain after credits", fires[2] - base, 1);

        // R8: resend after 3 periods, stopped by acknowledge
        wr(a_attr(1), mk(3, 0, 0, 2, 0));
        send(1, 1);
        wait_fire(1, 100, got);
        check(got, "R8 first request", int'(got), 1);
        base = fires[1];
        idle(70);
        check(fires[1] == base, "R8 no early resend", fires[1] - base, 0);
        idle(40);
        check(fires[1] - base == 1, "R8 resend", fires[1] - base, 1);
        @(negedge clk); msg_ack[1] = 1'b1;
        @(negedge clk); msg_ack[1] = 1'b0;
        base = fires[1];
        idle(200);
        check(fires[1] == base, "R8 ack stops resend", fires[1] - base, 0);

        // R9: clear word restarts the resend wait
        send(1, 1);
        wait_fire(1, 100, got);
        check(got, "R9 request before clear", int'(got), 1);
        base = fires[1];
        idle(48);
        wr(a_clr(1), 32'h2000_0000);
        idle(58);
        check(fires[1] == base, "R9 resend postponed", fires[1] - base, 0);
        idle(120);
        check(fires[1] - base >= 1, "R9 resend after restart", fires[1] - base, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule